// File: doc/BRIEF.md
# Block-mode SPI master with word FIFO

This block is a serial peripheral master that moves a programmed number of bytes in one direction per transfer. Software does not handle one byte per register access. Payload passes through a 32-bit word port in front of an 8-deep FIFO, and the serial engine packs or unpacks four bytes per word. Software first writes the byte count. It then writes the control word, which holds a clock code, one of four device selects and a direction. Setting the start/busy bit in that same write launches the transfer.

For outgoing transfers, software pushes words into the FIFO and the engine drains them. For incoming transfers, the engine fills the FIFO and software pops the words. A status bit tells software when the FIFO cannot be used in the current direction. If the FIFO runs dry on an outgoing transfer, or fills up on an incoming one, the engine stalls with the serial clock low. When the last byte is done, the block drops chip select and raises a sticky done flag, which software must clear by writing it to zero.

Top module: `spi_block_master`

## Requirements
- R1: The registers are at these offsets: control 0x00, done 0x04, length 0x08, FIFO 0x0C, status 0x10.
  - Control holds the clock code in bits 5:0, the device in bits 7:6, direction in bit 13 (1 = outgoing) and start/busy in bit 15. Its other bits read 0.
  - Length keeps its low 16 bits and reads back zero-extended.
  - Unmapped offsets read 0.
- R2: A control write with bit 15 set while idle and with a non-zero length starts a transfer. Control then reads bit 15 = 1, and only `spi_cs_n[device]` is driven low. A start with length 0 leaves the block idle.
- R3: The serial clock idles low. Each high phase lasts exactly code+1 core cycles, and so does each low phase within a byte. MOSI changes only while the clock is low. MISO is sampled on the rising edge. Bits go MSB first.
- R4: An outgoing transfer sends exactly length bytes, taking bytes from each FIFO word starting with the low byte (bits 7:0). Unused high bytes of the final word are discarded.
- R5: An incoming transfer packs the received bytes into words, the first byte in bits 7:0. A final partial word has zero in its unused high bytes. Each word is pushed into the FIFO.
- R6: The FIFO holds 8 words.
  - A write to the FIFO port when it is full is dropped.
  - A read of an empty FIFO returns 0.
  - Software reads do not pop during an outgoing transfer, and software writes do not push during an incoming transfer.
- R7: Status bit 0 reads the FIFO-full flag when the direction is outgoing and the FIFO-empty flag when it is incoming.
- R8: At the end of a transfer, busy clears, chip select goes high and done bit 0 reads 1. A write of a value with bit 0 = 0 to the done register clears it. A start also clears it.
- R9: Writes to control and length while busy are ignored.
- R10: An outgoing transfer with an empty FIFO, or an incoming one that must push into a full FIFO, stalls with the clock low and chip select held. It resumes when software supplies or removes a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at offset 0x0C) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low chip selects, one per device |

## Verification
The bench targets the following corner cases:
- **Byte count not a multiple of four.** A design that mishandles this sends stray high bytes on output, or leaves garbage in the final incoming word.
- **FIFO at capacity.** The bench writes a ninth word and moves 32 bytes. A FIFO with a wrong depth or a wrong full check would drop or send an extra word.
- **Stalls in both directions.** The bench starts an outgoing transfer with nothing queued and runs an incoming transfer longer than the FIFO. A design without back-pressure would clock out junk or overwrite unread words.
- **Reconfiguration while busy.** The bench writes control and length mid-transfer. A design that accepted those writes would switch chip select or change the clock rate partway through a block.

// File: rtl/spi_block_master.sv
module spi_block_master #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [3:0]  spi_cs_n
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [4:0] A_CTL = 5'h00, A_DONE = 5'h04, A_LEN = 5'h08, A_FIFO = 5'h0C, A_STAT = 5'h10;

  logic [5:0]       div;
  logic [1:0]       dev;
  logic             dir_out, busy, done, shifting, have, pend;
  logic [LEN_W-1:0] blklen, left;
  logic [5:0]       hc;
  logic [2:0]       bitn;
  logic [1:0]       lane;
  logic [7:0]       sh, rx;
  logic [31:0]      word;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  wire full  = cnt == (AW+1)'(DEPTH);
  wire empty = cnt == '0;
  wire last_byte = (lane == 2'd3) || (left == LEN_W'(1));

  wire sw_push  = bus_wr && bus_addr == A_FIFO && !full && !(busy && !dir_out);
  wire sw_pop   = bus_rd && bus_addr == A_FIFO && !empty && !(busy && dir_out);
  wire eng_pop  = busy && dir_out && !shifting && left != '0 && !have && !empty;
  wire eng_push = busy && !dir_out && !shifting && pend && !full;
  wire push = sw_push || eng_push;
  wire pop  = sw_pop || eng_pop;
  wire ctl_wr = bus_wr && bus_addr == A_CTL && !busy;
  wire edge_now = busy && shifting && hc == div;

  always_ff @(posedge clk) if (push) mem[wp] <= sw_push ? bus_wdata : word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div <= '0; dev <= '0; dir_out <= 1'b0; busy <= 1'b0; done <= 1'b0;
      blklen <= '0; left <= '0; hc <= '0; bitn <= '0; lane <= '0;
      sh <= '0; rx <= '0; word <= '0; shifting <= 1'b0; have <= 1'b0; pend <= 1'b0;
      spi_sclk <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_DONE && !bus_wdata[0]) done <= 1'b0;
      if (bus_wr && bus_addr == A_LEN && !busy) blklen <= bus_wdata[LEN_W-1:0];
      if (ctl_wr) begin
        div <= bus_wdata[5:0]; dev <= bus_wdata[7:6]; dir_out <= bus_wdata[13];
        if (bus_wdata[15] && blklen != '0) begin
          busy <= 1'b1; done <= 1'b0; left <= blklen; lane <= '0; word <= '0;
          have <= 1'b0; pend <= 1'b0; shifting <= 1'b0; hc <= '0; spi_sclk <= 1'b0;
        end
      end
      if (busy) begin
        if (shifting) begin
          if (hc == div) begin
            hc <= '0;
            spi_sclk <= !spi_sclk;
            if (!spi_sclk) rx <= {rx[6:0], spi_miso};
            else if (bitn == 3'd7) begin
              shifting <= 1'b0;
              left <= left - 1'b1;
              lane <= lane + 1'b1;
              if (!dir_out) begin
                word[{lane, 3'b000} +: 8] <= rx;
                pend <= last_byte;
              end else if (last_byte) have <= 1'b0;
            end else begin
              bitn <= bitn + 1'b1;
              sh <= {sh[6:0], 1'b0};
            end
          end else hc <= hc + 1'b1;
        end else if (dir_out) begin
          if (left == '0) begin
            busy <= 1'b0; done <= 1'b1;
          end else if (have) begin
            sh <= word[{lane, 3'b000} +: 8]; shifting <= 1'b1; bitn <= '0; hc <= '0;
          end else if (!empty) begin
            word <= mem[rp]; have <= 1'b1; lane <= '0;
          end
        end else begin
          if (pend) begin
            if (!full) begin pend <= 1'b0; word <= '0; lane <= '0; end
          end else if (left == '0) begin
            busy <= 1'b0; done <= 1'b1;
          end else begin
            sh <= '0; shifting <= 1'b1; bitn <= '0; hc <= '0;
          end
        end
      end
    end

  assign spi_mosi = shifting && dir_out && sh[7];

  for (genvar i = 0; i < 4; i++) begin : g_cs
    assign spi_cs_n[i] = !(busy && dev == 2'(i));
  end

  always_comb
    case (bus_addr)
      A_CTL:   bus_rdata = {16'b0, busy, 1'b0, dir_out, 5'b0, dev, div};
      A_DONE:  bus_rdata = {31'b0, done};
      A_LEN:   bus_rdata = {{(32-LEN_W){1'b0}}, blklen};
      A_FIFO:  bus_rdata = empty ? 32'b0 : mem[rp];
      A_STAT:  bus_rdata = {31'b0, dir_out ? full : empty};
      default: bus_rdata = 32'b0;
    endcase

  a_r3_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> !(&spi_cs_n));
  a_r3_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sclk) |-> $stable(spi_mosi));
  a_r8_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done && (&spi_cs_n));
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  a_r9_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(blklen) && $stable(dev) && $stable(div));
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));
  a_r3_edge_paced: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(spi_sclk) |-> $past(edge_now));
endmodule

// File: tb/spi_block_master_test.sv
module spi_block_master_test;
  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso = 0;
  logic [3:0] spi_cs_n;

  spi_block_master uut (.*);

  always #4 clk = !clk;

  int compared = 0, mismatched = 0;
  logic [7:0] txq[$], rxq[$], expq[$];
  logic [7:0] rsh = 0, tcur = 0;
  int rbits = 0, tbits = 0, hi_len = 0, rises = 0;
  int exp_dev = 0, exp_div = 0;
  bit mon_en = 0;
  wire cs_all = &spi_cs_n;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // SPI slave model (mode 0)
  always @(negedge cs_all) begin
    rbits = 0; tbits = 0;
    tcur = txq.size() > 0 ? txq.pop_front() : 8'h00;
    spi_miso = tcur[7];
  end
  always @(posedge spi_sclk) begin
    rises++;
    rsh = {rsh[6:0], spi_mosi};
    rbits++;
    if (rbits == 8) begin rxq.push_back(rsh); rbits = 0; end
  end
  always @(negedge spi_sclk) begin
    tbits++;
    if (tbits == 8) begin
      tbits = 0;
      tcur = txq.size() > 0 ? txq.pop_front() : 8'h00;
    end
    spi_miso = tcur[7 - tbits];
  end

  // per-clock comparison against the expected line behaviour
  always @(negedge clk) if (rst_n && mon_en) begin
    logic [3:0] sel;
    sel = ~(4'b1 << exp_dev);
    chk(spi_cs_n == 4'hF || spi_cs_n == sel, "R2 chip select", {28'b0, spi_cs_n}, {28'b0, sel});
    chk(!(spi_sclk && cs_all), "R3 sclk idle low", {31'b0, spi_sclk}, 0);
    if (spi_sclk) hi_len++;
    else if (hi_len > 0) begin
      chk(hi_len == exp_div + 1, "R3 half period", hi_len, exp_div + 1);
      hi_len = 0;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic wait_done();
    logic [31:0] d;
    for (int i = 0; i < 20000; i++) begin
      rd(5'h04, d);
      if (d[0]) return;
    end
    chk(0, "R8 done timeout", 0, 1);
  endtask
  task automatic chk_rx(input string req);
    chk(rxq.size() == expq.size(), req, rxq.size(), expq.size());
    for (int i = 0; i < expq.size() && i < rxq.size(); i++)
      chk(rxq[i] == expq[i], req, {24'b0, rxq[i]}, {24'b0, expq[i]});
  endtask
  function automatic logic [31:0] ctl(input int div, input int dev, input bit out, input bit go);
    return {16'b0, go, 1'b0, out, 5'b0, 2'(dev), 6'(div)};
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_en = 1;
    // reset state
    rd(5'h00, d); chk(d == 0, "R1 reset ctrl", d, 0);
    rd(5'h04, d); chk(d == 0, "R8 reset done", d, 0);
    rd(5'h08, d); chk(d == 0, "R1 reset len", d, 0);
    rd(5'h10, d); chk(d == 1, "R7 reset status empty", d, 1);
    rd(5'h0C, d); chk(d == 0, "R6 empty read", d, 0);
    chk(spi_cs_n == 4'hF, "R2 reset cs", {28'b0, spi_cs_n}, 32'hF);

    // R1 field readback
    wr(5'h00, 32'h0000_7F85); rd(5'h00, d); chk(d == 32'h2085, "R1 ctrl fields", d, 32'h2085);
    wr(5'h08, 32'hFFFF_0007); rd(5'h08, d); chk(d == 32'h7, "R1 len width", d, 7);
    rd(5'h14, d); chk(d == 0, "R1 unmapped", d, 0);

    // R2 start with zero length ignored
    wr(5'h08, 0); wr(5'h00, ctl(0, 1, 1, 1));
    rd(5'h00, d); chk(d[15] == 0, "R2 zero length", d, 0);

    // R4 outgoing 7 bytes, partial word
    exp_dev = 1; exp_div = 0; rxq.delete(); expq = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
    wr(5'h0C, 32'h4433_2211); wr(5'h0C, 32'hAA77_6655);
    wr(5'h08, 7); wr(5'h00, ctl(0, 1, 1, 1));
    rd(5'h00, d); chk(d[15] == 1, "R2 busy reads 1", d, 1);
    chk(spi_cs_n == 4'b1101, "R2 cs device 1", {28'b0, spi_cs_n}, 32'hD);
    wait_done();
    chk_rx("R4 outgoing bytes");
    rd(5'h00, d); chk(d[15] == 0, "R8 busy cleared", d, 0);
    chk(spi_cs_n == 4'hF, "R8 cs released", {28'b0, spi_cs_n}, 32'hF);
    wr(5'h04, 1); rd(5'h04, d); chk(d == 1, "R8 write 1 keeps done", d, 1);
    wr(5'h04, 0); rd(5'h04, d); chk(d == 0, "R8 done cleared", d, 0);

    // R5 incoming 6 bytes
    exp_dev = 0; exp_div = 2;
    txq = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6};
    wr(5'h08, 6); wr(5'h00, ctl(2, 0, 0, 1));
    wait_done();
    rd(5'h0C, d); chk(d == 32'hA4A3_A2A1, "R5 first word", d, 32'hA4A3A2A1);
    rd(5'h0C, d); chk(d == 32'h0000_A6A5, "R5 partial word", d, 32'h0000A6A5);
    rd(5'h10, d); chk(d == 1, "R7 empty after drain", d, 1);
    wr(5'h00, ctl(2, 0, 0, 1)); rd(5'h04, d); chk(d == 0, "R8 start clears done", d, 0);
    wait_done(); rd(5'h0C, d); rd(5'h0C, d); txq.delete();

    // R6/R7 fill FIFO, ninth word dropped, 32 outgoing bytes
    exp_dev = 3; exp_div = 1; rxq.delete(); expq.delete();
    wr(5'h00, ctl(1, 3, 1, 0));
    for (int i = 0; i < 8; i++) wr(5'h0C, 32'h0302_0100 + i * 32'h0404_0404);
    rd(5'h10, d); chk(d == 1, "R7 full status", d, 1);
    wr(5'h0C, 32'hDEAD_BEEF);
    for (int i = 0; i < 32; i++) expq.push_back(8'(i));
    wr(5'h08, 32); wr(5'h00, ctl(1, 3, 1, 1));
    wait_done();
    chk_rx("R6 depth and order");
    rd(5'h0C, d); chk(d == 0, "R6 ninth word dropped", d, 0);

    // R10 outgoing stall, R9 writes while busy
    exp_dev = 2; exp_div = 0; rxq.delete(); expq = '{8'h5A, 8'hC3, 8'h0F, 8'hF0};
    wr(5'h08, 4); wr(5'h00, ctl(0, 2, 1, 1));
    rises = 0;
    repeat (50) @(negedge clk);
    chk(rises == 0, "R10 stall no clock", rises, 0);
    chk(spi_cs_n == 4'b1011, "R10 cs held", {28'b0, spi_cs_n}, 32'hB);
    wr(5'h00, ctl(9, 1, 0, 0)); wr(5'h08, 99);
    rd(5'h00, d); chk(d == 32'hA080, "R9 ctrl unchanged", d, 32'hA080);
    rd(5'h08, d); chk(d == 4, "R9 len unchanged", d, 4);
    wr(5'h0C, 32'hF00F_C35A);
    wait_done();
    chk_rx("R10 resumed bytes");

    // R10 incoming overrun stall, 40 bytes
    exp_dev = 1; exp_div = 0;
    for (int i = 0; i < 40; i++) txq.push_back(8'(i * 7 + 3));
    wr(5'h08, 40); wr(5'h00, ctl(0, 1, 0, 1));
    repeat (1500) @(negedge clk);
    rd(5'h00, d); chk(d[15] == 1, "R10 stalled on full", d, 1);
    for (int w = 0; w < 10; w++) begin
      logic [31:0] e;
      for (int g = 0; g < 5000; g++) begin
        rd(5'h10, d);
        if (!d[0]) break;
      end
      e = 0;
      for (int b = 0; b < 4; b++) e[b*8 +: 8] = 8'((w*4 + b) * 7 + 3);
      rd(5'h0C, d); chk(d == e, "R5 incoming word", d, e);
    end
    wait_done();
    rd(5'h10, d); chk(d == 1, "R7 empty at end", d, 1);
    mon_en = 0;
    finish_run();
  end
endmodule